// File: doc/BRIEF.md
# Branch Sample Recording Buffer

This block captures the source and target addresses of retired taken branches into a small register file. Software arms it by setting the record enable bit in a 64-bit configuration/status register. From then on, every taken-branch strobe writes one from/to pair at the next-write index, and the index then steps by one. The buffer fills in a single pass and does not wrap as a ring. When the last entry has been written, the index returns to zero and the block clears its own enable bit. The valid flag and the index remain readable afterwards.

The block also gates the overflow event of the performance counter that drives sampling. While recording is enabled, an overflow pulse is held back. It is released as a one-cycle interrupt pulse when the buffer becomes full, or when software clears the enable bit. An overflow that arrives while recording is off is passed straight through. The entries can be read and written through a register-mapped port. Entry i has its source register at address 2*i and its target register at address 2*i+1. Software can therefore plant a marker value in an entry without disturbing the recording state.

Top module: `brsamp_buf`

## Requirements
- R1: After reset the configuration register reads 64'h18, which means enable 0, valid flag 0 and index 0, and `irq` is low.
- R2: While the enable bit (bit 2) is set, each `br_valid` cycle without a configuration write stores `br_from`/`br_to` into entry N. N is the index in bits 19:16, and the index then becomes N+1.
- R3: While the enable bit is clear, `br_valid` changes neither the entries nor the index nor the valid flag.
- R4: The capture into the last entry (15) returns the index to 0 and clears the enable bit, and the valid flag is kept. Later branches overwrite nothing.
- R5: The valid flag (bit 5) becomes 1 on the first capture. It stays 1 until software writes the configuration register with bit 5 clear.
- R6: A configuration write loads the enable bit (2), the valid flag (5), the index (19:16) and the counter-select field (26:24). Bits 4:3 always read 11 and every other bit reads 0.
- R7: An `ovf_pulse` that arrives while enabled is held, and `irq` stays low until the buffer becomes full. `irq` is then high for the one cycle after the capture into entry 15.
- R8: A held overflow is released as an `irq` pulse in the cycle after a configuration write that clears the enable bit.
- R9: An `ovf_pulse` that arrives while the enable bit is clear gives an `irq` pulse in the next cycle.
- R10: A write on the entry port changes only the addressed register. Address bit 0 selects the target (1) or the source (0) register, and bits 4:1 select the entry. The write leaves the index and the valid flag unchanged.
- R11: Writing zero to the configuration register clears the enable bit, the valid flag and the index, and reads back 64'h18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | Retired taken branch strobe |
| br_from | input | 64 | Branch source address |
| br_to | input | 64 | Branch target address |
| ovf_pulse | input | 1 | Overflow pulse of the selected counter |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration/status readback |
| ent_we | input | 1 | Entry register write strobe |
| ent_addr | input | 5 | Entry register address (2*i source, 2*i+1 target) |
| ent_wdata | input | 64 | Entry write data |
| ent_rdata | output | 64 | Entry register readback (combinational) |
| irq | output | 1 | Released overflow interrupt pulse |

## Verification
The assertions assume three things about the inputs:
- the entry port never writes the entry being captured in the same cycle;
- a configuration write and a branch strobe are not issued together, since a configuration write takes priority and drops the branch;
- strobes are single-cycle and synchronous to the clock.

The stimulus drives every input one at a time on the falling edge. It writes entries only while recording is off or into entries other than the current index. Because of this, the held-interrupt and saturation properties apply to clean single events.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int CFG_W   = 64;
  localparam int IDXF_W  = 4;
  localparam int SELF_W  = 3;
  localparam int EN_BIT  = 2;
  localparam int VB_BIT  = 5;
  localparam int IDX_LO  = 16;
  localparam int SEL_LO  = 24;

  typedef struct packed {
    logic              en;
    logic              vb;
    logic [IDXF_W-1:0] idx;
    logic [SELF_W-1:0] sel;
  } rec_state_t;

  function automatic logic [IDXF_W-1:0] idx_step(input logic [IDXF_W-1:0] i,
                                                  input int depth);
    return (int'(i) == depth - 1) ? '0 : i + 1'b1;
  endfunction

  function automatic logic idx_is_last(input logic [IDXF_W-1:0] i, input int depth);
    return int'(i) == depth - 1;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input rec_state_t s);
    logic [CFG_W-1:0] v;
    v = '0;
    v[EN_BIT] = s.en;
    v[4:3] = 2'b11;
    v[VB_BIT] = s.vb;
    v[IDX_LO +: IDXF_W] = s.idx;
    v[SEL_LO +: SELF_W] = s.sel;
    return v;
  endfunction

  function automatic rec_state_t cfg_unpack(input logic [CFG_W-1:0] v);
    rec_state_t s;
    s.en  = v[EN_BIT];
    s.vb  = v[VB_BIT];
    s.idx = v[IDX_LO +: IDXF_W];
    s.sel = v[SEL_LO +: SELF_W];
    return s;
  endfunction
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              ovf_pulse,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [IDXF_W-1:0] wr_idx,
  output logic              cap_evt,
  output logic              full_evt,
  output logic              dis_evt,
  output logic              pend,
  output logic              irq
);
  rec_state_t st_q, st_d;
  logic pend_any, fire;

  always_comb begin
    cap_evt  = st_q.en & br_valid & ~cfg_we;
    full_evt = cap_evt & idx_is_last(st_q.idx, DEPTH);
    dis_evt  = cfg_we & st_q.en & ~cfg_wdata[EN_BIT];
    pend_any = pend | (ovf_pulse & st_q.en);
    fire     = (pend_any & (full_evt | dis_evt)) | (ovf_pulse & ~st_q.en);
  end

  always_comb begin
    st_d = st_q;
    if (cfg_we) begin
      st_d = cfg_unpack(cfg_wdata);
    end else if (cap_evt) begin
      st_d.vb  = 1'b1;
      st_d.idx = idx_step(st_q.idx, DEPTH);
      if (full_evt) st_d.en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_d;
      pend <= pend_any & ~(full_evt | dis_evt);
      irq  <= fire;
    end
  end

  assign cfg_rdata = cfg_pack(st_q);
  assign wr_idx    = st_q.idx;
endmodule

// File: rtl/brs_store.sv
module brs_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_evt,
  input  logic [IW-1:0] cap_idx,
  input  logic [AW-1:0] cap_from,
  input  logic [AW-1:0] cap_to,
  input  logic          sw_we,
  input  logic [RW-1:0] sw_addr,
  input  logic [AW-1:0] sw_wdata,
  output logic [AW-1:0] sw_rdata
);
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit_cap, hit_src, hit_dst;
    assign hit_cap = cap_evt && (int'(cap_idx) == i);
    assign hit_src = sw_we && (int'(sw_addr[RW-1:1]) == i) && !sw_addr[0];
    assign hit_dst = sw_we && (int'(sw_addr[RW-1:1]) == i) &&  sw_addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end else if (hit_cap) begin
        src_q[i] <= cap_from;
        dst_q[i] <= cap_to;
      end else begin
        if (hit_src) src_q[i] <= sw_wdata;
        if (hit_dst) dst_q[i] <= sw_wdata;
      end
    end
  end

  assign sw_rdata = sw_addr[0] ? dst_q[sw_addr[RW-1:1]] : src_q[sw_addr[RW-1:1]];
endmodule

// File: rtl/brsamp_buf.sv
module brsamp_buf
  import brs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [AW-1:0] br_from,
  input  logic [AW-1:0] br_to,
  input  logic          ovf_pulse,
  input  logic          cfg_we,
  input  logic [63:0]   cfg_wdata,
  output logic [63:0]   cfg_rdata,
  input  logic          ent_we,
  input  logic [RW-1:0] ent_addr,
  input  logic [AW-1:0] ent_wdata,
  output logic [AW-1:0] ent_rdata,
  output logic          irq
);
  logic [IDXF_W-1:0] wr_idx;
  logic cap_evt, full_evt, dis_evt, pend;

  brs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .ovf_pulse(ovf_pulse),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wr_idx(wr_idx), .cap_evt(cap_evt), .full_evt(full_evt),
    .dis_evt(dis_evt), .pend(pend), .irq(irq)
  );

  brs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cap_idx(wr_idx[IW-1:0]),
    .cap_from(br_from), .cap_to(br_to), .sw_we(ent_we), .sw_addr(ent_addr),
    .sw_wdata(ent_wdata), .sw_rdata(ent_rdata)
  );
endmodule

// File: rtl/brs_chk.sv
module brs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [63:0] cfg_rdata,
  input logic        cap_evt,
  input logic        full_evt,
  input logic        dis_evt,
  input logic        pend,
  input logic        irq
);
  // R2
  idx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && !full_evt |=> cfg_rdata[19:16] == $past(cfg_rdata[19:16]) + 4'd1);
  // R4
  full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> !cfg_rdata[2] && cfg_rdata[19:16] == 4'd0 && cfg_rdata[5]);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[2] && !cfg_we |=> $stable(cfg_rdata[19:16]) && $stable(cfg_rdata[5]));
  // R5
  vb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cfg_rdata[5]);
  // R7
  held_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> cfg_rdata[2]);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && (full_evt || dis_evt) |=> irq && !pend);
endmodule

bind brsamp_buf brs_chk i_brs_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .cap_evt(cap_evt), .full_evt(full_evt), .dis_evt(dis_evt),
  .pend(pend), .irq(irq)
);

// File: tb/test_brsamp_buf.sv
module test_brsamp_buf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 1'b0, ovf_pulse = 1'b0, cfg_we = 1'b0, ent_we = 1'b0;
  logic [63:0] br_from = '0, br_to = '0, cfg_wdata = '0, ent_wdata = '0;
  logic [4:0]  ent_addr = '0;
  logic [63:0] cfg_rdata, ent_rdata;
  logic irq;

  int total = 0, bad = 0;
  bit m_en = 0, m_vb = 0, m_pend = 0, m_irq = 0;
  int m_idx = 0;

  typedef struct { int idx; logic [63:0] f; logic [63:0] t; } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  brsamp_buf i_brsamp_buf (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
    .ovf_pulse(ovf_pulse), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ent_we(ent_we), .ent_addr(ent_addr), .ent_wdata(ent_wdata), .ent_rdata(ent_rdata),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_cfg();
    return 64'h18 | (64'(m_en) << 2) | (64'(m_vb) << 5) | (64'(m_idx) << 16);
  endfunction

  // one clock; inputs set beforehand at a falling edge; model advances alongside
  task automatic cyc();
    bit cap, full, dis, pany;
    cap  = m_en && br_valid && !cfg_we;
    full = cap && m_idx == 15;
    dis  = cfg_we && m_en && !cfg_wdata[2];
    pany = m_pend || (ovf_pulse && m_en);
    m_irq = (pany && (full || dis)) || (ovf_pulse && !m_en);
    m_pend = pany && !(full || dis);
    if (cfg_we) begin
      m_en = cfg_wdata[2]; m_vb = cfg_wdata[5]; m_idx = int'(cfg_wdata[19:16]);
    end else if (cap) begin
      sbq.push_back('{m_idx, br_from, br_to});
      m_vb = 1; m_idx = (m_idx + 1) % 16;
      if (full) m_en = 0;
    end
    @(posedge clk); @(negedge clk);
    br_valid = 0; ovf_pulse = 0; cfg_we = 0; ent_we = 0;
    chk("R7/R8/R9 irq", 64'(irq), 64'(m_irq));
  endtask

  task automatic branch(input logic [63:0] f, input logic [63:0] t, input bit ovf = 0);
    br_valid = 1; br_from = f; br_to = t; ovf_pulse = ovf; cyc();
  endtask

  task automatic cfg_wr(input logic [63:0] v);
    cfg_we = 1; cfg_wdata = v; cyc();
  endtask

  // monitor: pops expected entries and compares with the register file
  task automatic drain();
    while (sbq.size() > 0) begin
      exp_t e = sbq.pop_front();
      ent_addr = 5'(2 * e.idx); #1;
      chk("R2 from", ent_rdata, e.f);
      ent_addr = 5'(2 * e.idx + 1); #1;
      chk("R2 to", ent_rdata, e.t);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (2) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R1 cfg", cfg_rdata, 64'h18);
    chk("R1 irq", 64'(irq), 0);

    // R3: branch while disabled is dropped
    branch(64'hAAAA, 64'hBBBB);
    chk("R3 cfg", cfg_rdata, 64'h18);
    ent_addr = 0; #1; chk("R3 entry0", ent_rdata, 0);

    // R9: overflow while disabled passes through
    ovf_pulse = 1; cyc();

    // R6: enable with counter select 3
    cfg_wr(64'h0300_0004);
    chk("R6 cfg", cfg_rdata, 64'h0300_001C);

    // R7: fill, with overflow held in the middle
    for (int i = 0; i < 16; i++) begin
      branch(64'h1000 + 64'(i), 64'h2000 + 64'(i), i == 5);
      if (i == 0) chk("R5 vb set", 64'(cfg_rdata[5]), 1);
    end
    chk("R4 full cfg", cfg_rdata, 64'h0300_0038);
    drain();
    branch(64'hDEAD, 64'hBEEF);
    chk("R4 no overwrite idx", cfg_rdata, 64'h0300_0038);
    ent_addr = 0; #1; chk("R4 entry0 kept", ent_rdata, 64'h1000);

    // R10: marker write to target of entry 7
    ent_we = 1; ent_addr = 5'd15; ent_wdata = 64'hFFFF_FFFF_FFFF_FFFE; cyc();
    chk("R10 cfg kept", cfg_rdata, 64'h0300_0038);
    ent_addr = 5'd15; #1; chk("R10 marker", ent_rdata, 64'hFFFF_FFFF_FFFF_FFFE);
    ent_addr = 5'd14; #1; chk("R10 src kept", ent_rdata, 64'h1007);
    ent_addr = 5'd17; #1; chk("R10 neighbour", ent_rdata, 64'h2008);

    // R11: write zero
    cfg_wr(64'h0);
    chk("R11 cfg", cfg_rdata, 64'h18);

    // R8: disable while held
    cfg_wr(64'h4);
    for (int i = 0; i < 3; i++) branch(64'h3000 + 64'(i), 64'h4000 + 64'(i));
    ovf_pulse = 1; cyc();
    chk("R7 held irq", 64'(irq), 0);
    cfg_wr(64'h20);
    chk("R8 cfg", cfg_rdata, exp_cfg());
    chk("R5 vb kept", 64'(cfg_rdata[5]), 1);
    drain();

    // R6: all-ones write, then one capture fills the buffer
    cfg_wr('1);
    chk("R6 reserved", cfg_rdata, 64'h070F_003C);
    branch(64'h5555, 64'h6666);
    chk("R4 last cfg", cfg_rdata, 64'h0700_0038);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule